// File: doc/BRIEF.md
# Coprocessor Interrupt Register Block

This block gives a host processor a view of the completion events and handshake levels of a cryptographic coprocessor. The host reaches it over a simple synchronous bus that carries one word per access. Four engine completion events arrive as single-cycle pulses: block cipher done, hash done, packet done and exponentiation done. Each pulse sets a sticky bit in a status word, and the bit stays set until the host writes a one to it. Two handshake levels, input-ready and output-ready, also appear in the same status word. These two bits are not stored; they always show the current level of their inputs.

An enable word selects which status bits may raise the interrupt. The interrupt output is high whenever any status bit and its enable bit are both one. The host treats it as a level interrupt: it reads the status, clears the events it has handled, and the line drops once no enabled bit remains set. A third word holds configuration for the rest of the coprocessor and is presented on an output port.

A bus access lasts one cycle. A write takes effect at the clock edge that ends it. Read data is registered: it appears on the cycle after the request and holds until the next read.

Top module: `crypto_irq_regs`

## Requirements
- R1: After reset, the status, enable and configuration words all read 0x00000000 and irq_o is low.
- R2: The status word is at word address 0x400, enable at 0x401 and configuration at 0x402. Read data appears on bus_rdata in the cycle after the read request and holds until the next read request.
- R3: A one on eng_done_i sets a sticky status bit that stays set. The bit positions are: eng_done_i[0] (cipher done) sets bit 0, [1] (hash done) sets bit 1, [2] (packet done) sets bit 2 and [3] (exponentiation done) sets bit 7.
- R4: Writing the status word clears each sticky bit whose data bit is one. Sticky bits whose data bit is zero are left unchanged.
- R5: When a done pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R6: Status bit 3 reads the current level of live_rdy_i[0] (input-ready) and bit 4 reads the current level of live_rdy_i[1] (output-ready). Writes to these two bits have no effect.
- R7: Reserved status bits 31:8, 6 and 5 always read zero. Writing them has no effect on any status bit.
- R8: The enable and configuration words are full 32-bit read/write registers. cfg_o always shows the stored configuration word.
- R9: irq_o is high exactly when some bit is one in both the status word (sticky and live bits) and the enable word. It follows changes without an added register stage.
- R10: A read from any address other than 0x400 to 0x402 returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (11) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_done_i | input | 4 | Engine completion pulses: cipher, hash, packet, exponentiation |
| live_rdy_i | input | 2 | Live levels: [0] input-ready, [1] output-ready |
| cfg_o | output | 32 | Stored configuration word |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
Single done pulses and a multi-bit pulse pattern show that each event lands on its own bit position and that separate events do not disturb one another. Clearing writes use single-bit, zero, multi-bit and all-reserved data patterns. These tell apart a correct write-one-to-clear from a plain write, an inverted clear, and leakage into the reserved or live bits. A write that coincides with a pulse on the same bit exposes a clear-wins priority. Enable words with one bit set, aimed at a sticky bit or at a live bit, separate a correct AND-then-OR interrupt from one that ignores the mask or leaves out the live levels. Reads and writes at unmapped addresses next to the three real ones catch incomplete address decoding.

// File: rtl/crypto_irq_pkg.sv
package crypto_irq_pkg;

  localparam int WORD_W   = 32;
  localparam int NUM_EVT  = 4;
  localparam int NUM_LIVE = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_STAT,
    RSEL_EN,
    RSEL_CFG
  } rsel_e;

  // bit position of each sticky event in the status word
  function automatic int evt_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 7;
    endcase
  endfunction

  // bit position of each live level in the status word
  function automatic int live_pos(input int idx);
    return (idx == 0) ? 3 : 4;
  endfunction

  function automatic word_t pack_status(input logic [NUM_EVT-1:0]  evt,
                                        input logic [NUM_LIVE-1:0] live);
    word_t w;
    w = '0;
    for (int i = 0; i < NUM_EVT; i++)  w[evt_pos(i)]  = evt[i];
    for (int j = 0; j < NUM_LIVE; j++) w[live_pos(j)] = live[j];
    return w;
  endfunction

  function automatic logic [NUM_EVT-1:0] clear_mask(input word_t wd);
    logic [NUM_EVT-1:0] m;
    for (int i = 0; i < NUM_EVT; i++) m[i] = wd[evt_pos(i)];
    return m;
  endfunction

  function automatic logic irq_reduce(input word_t st, input word_t en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/crypto_irq_decode.sv
module crypto_irq_decode
  import crypto_irq_pkg::*;
#(
  parameter int                ADDR_W    = 11,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 11'h400,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 11'h401,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 11'h402
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_stat,
  output logic              wr_en,
  output logic              wr_cfg,
  output logic              rd_strobe,
  output rsel_e             rd_sel,
  output logic              rd_unmapped
);

  always_comb begin
    rd_sel = RSEL_NONE;
    if (addr == STAT_ADDR)     rd_sel = RSEL_STAT;
    else if (addr == EN_ADDR)  rd_sel = RSEL_EN;
    else if (addr == CFG_ADDR) rd_sel = RSEL_CFG;
  end

  assign wr_stat     = sel && we && (rd_sel == RSEL_STAT);
  assign wr_en       = sel && we && (rd_sel == RSEL_EN);
  assign wr_cfg      = sel && we && (rd_sel == RSEL_CFG);
  assign rd_strobe   = sel && !we;
  assign rd_unmapped = rd_strobe && (rd_sel == RSEL_NONE);

endmodule

// File: rtl/crypto_irq_sticky.sv
module crypto_irq_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set has priority over clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/crypto_irq_rwreg.sv
module crypto_irq_rwreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q_o <= '0;
    else if (we) q_o <= wdata;
  end

endmodule

// File: rtl/crypto_irq_rdport.sv
module crypto_irq_rdport
  import crypto_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_strobe,
  input  rsel_e rd_sel,
  input  word_t stat_word,
  input  word_t en_word,
  input  word_t cfg_word,
  output word_t rdata_o
);

  word_t rd_next;

  always_comb begin
    case (rd_sel)
      RSEL_STAT: rd_next = stat_word;
      RSEL_EN:   rd_next = en_word;
      RSEL_CFG:  rd_next = cfg_word;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata_o <= '0;
    else if (rd_strobe) rdata_o <= rd_next;
  end

endmodule

// File: rtl/crypto_irq_regs.sv
module crypto_irq_regs
  import crypto_irq_pkg::*;
#(
  parameter int                ADDR_W    = 11,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 11'h400,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 11'h401,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 11'h402
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NUM_EVT-1:0]  eng_done_i,
  input  logic [NUM_LIVE-1:0] live_rdy_i,
  output logic [WORD_W-1:0]   cfg_o,
  output logic                irq_o
);

  // named internal events, brought out for the checker
  logic               wr_stat, wr_en, wr_cfg;
  logic               rd_strobe, rd_unmapped;
  rsel_e              rd_sel;
  logic [NUM_EVT-1:0] evt_clr;
  logic [NUM_EVT-1:0] evt_q;
  word_t              en_q;
  word_t              cfg_q;
  word_t              stat_word;

  crypto_irq_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_decode (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wr_stat(wr_stat), .wr_en(wr_en), .wr_cfg(wr_cfg),
    .rd_strobe(rd_strobe), .rd_sel(rd_sel), .rd_unmapped(rd_unmapped)
  );

  assign evt_clr = wr_stat ? clear_mask(bus_wdata) : '0;

  crypto_irq_sticky #(.N(NUM_EVT)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(eng_done_i), .clr_i(evt_clr), .q_o(evt_q)
  );

  crypto_irq_rwreg #(.W(WORD_W)) u_enable (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wdata(bus_wdata), .q_o(en_q)
  );

  crypto_irq_rwreg #(.W(WORD_W)) u_config (
    .clk(clk), .rst_n(rst_n), .we(wr_cfg), .wdata(bus_wdata), .q_o(cfg_q)
  );

  assign stat_word = pack_status(evt_q, live_rdy_i);

  crypto_irq_rdport u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_sel(rd_sel),
    .stat_word(stat_word), .en_word(en_q), .cfg_word(cfg_q), .rdata_o(bus_rdata)
  );

  assign cfg_o = cfg_q;
  assign irq_o = irq_reduce(stat_word, en_q);

endmodule

// File: rtl/crypto_irq_chk.sv
module crypto_irq_chk
  import crypto_irq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_EVT-1:0]  eng_done_i,
  input logic [NUM_EVT-1:0]  evt_clr,
  input logic [NUM_EVT-1:0]  evt_q,
  input logic                rd_unmapped,
  input logic [WORD_W-1:0]   bus_rdata,
  input logic [WORD_W-1:0]   en_q,
  input logic [NUM_LIVE-1:0] live_rdy_i,
  input logic                irq_o
);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    p_evt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done_i[i] |=> evt_q[i]);

    p_evt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_done_i[i] && !evt_clr[i]) |=> $stable(evt_q[i]));

    p_evt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr[i] && !eng_done_i[i]) |=> !evt_q[i]);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr[i] && eng_done_i[i]) |=> evt_q[i]);
  end

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (bus_rdata == '0));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);

  p_irq_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[3] && live_rdy_i[0]) |-> irq_o);

endmodule

bind crypto_irq_regs crypto_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_done_i(eng_done_i), .evt_clr(evt_clr),
  .evt_q(evt_q), .rd_unmapped(rd_unmapped), .bus_rdata(bus_rdata),
  .en_q(en_q), .live_rdy_i(live_rdy_i), .irq_o(irq_o)
);

// File: tb/tb_crypto_irq_regs.sv
module tb_crypto_irq_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  eng_done_i = '0;
  logic [1:0]  live_rdy_i = '0;
  logic [31:0] cfg_o;
  logic        irq_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  crypto_irq_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_done_i(eng_done_i), .live_rdy_i(live_rdy_i), .cfg_o(cfg_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one read request, expected value pushed to the scoreboard
  task automatic rd(input logic [10:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr_pulse(input logic [10:0] a, input logic [31:0] d, input logic [3:0] p);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; eng_done_i = p;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; eng_done_i = '0;
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    wr_pulse(a, d, 4'b0000);
  endtask

  task automatic pulse(input logic [3:0] p);
    @(negedge clk);
    eng_done_i = p;
    @(negedge clk);
    eng_done_i = '0;
  endtask

  task automatic set_live(input logic [1:0] v);
    @(negedge clk);
    live_rdy_i = v;
    #1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // monitor: pops expected read data and compares one cycle after the request
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_sel && !bus_we && exp_q.size() > 0) begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        @(negedge clk);
        chk(bus_rdata, e, t);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk({31'b0, irq_o}, 32'h0, "R1 irq after reset");
    rd(11'h400, 32'h0, "R1 status reset");
    rd(11'h401, 32'h0, "R1 enable reset");
    rd(11'h402, 32'h0, "R1 config reset");

    // R8 enable and configuration
    wr(11'h401, 32'hFFFF_FFFF);
    rd(11'h401, 32'hFFFF_FFFF, "R8 enable readback");
    wr(11'h402, 32'hA5A5_3C3C);
    rd(11'h402, 32'hA5A5_3C3C, "R8 config readback");
    chk(cfg_o, 32'hA5A5_3C3C, "R8 cfg_o");
    chk({31'b0, irq_o}, 32'h0, "R9 no status no irq");

    // R3 event latching
    pulse(4'b0001);
    rd(11'h400, 32'h0000_0001, "R3 cipher done bit0");
    chk({31'b0, irq_o}, 32'h1, "R9 irq on event");
    pulse(4'b1110);
    rd(11'h400, 32'h0000_0087, "R3 hash packet expo bits");

    // R4 write one to clear
    wr(11'h400, 32'h0000_0001);
    rd(11'h400, 32'h0000_0086, "R4 clear bit0");
    wr(11'h400, 32'h0000_0000);
    rd(11'h400, 32'h0000_0086, "R4 zero write keeps");
    wr(11'h400, 32'h0000_0006);
    rd(11'h400, 32'h0000_0080, "R4 clear bits 2 1");

    // R5 set wins over clear
    wr_pulse(11'h400, 32'h0000_0080, 4'b1000);
    rd(11'h400, 32'h0000_0080, "R5 set wins");
    wr(11'h400, 32'h0000_0080);
    rd(11'h400, 32'h0000_0000, "R4 clear bit7");
    chk({31'b0, irq_o}, 32'h0, "R9 irq drops");

    // R6 live bits
    set_live(2'b01);
    chk({31'b0, irq_o}, 32'h1, "R9 irq from input-ready");
    rd(11'h400, 32'h0000_0008, "R6 input-ready bit3");
    set_live(2'b11);
    rd(11'h400, 32'h0000_0018, "R6 both live bits");
    wr(11'h400, 32'h0000_0018);
    rd(11'h400, 32'h0000_0018, "R6 write to live ignored");
    set_live(2'b00);
    rd(11'h400, 32'h0000_0000, "R6 live follows low");
    chk({31'b0, irq_o}, 32'h0, "R9 live low no irq");

    // R7 reserved bits
    pulse(4'b1111);
    wr(11'h400, 32'hFFFF_FF60);
    rd(11'h400, 32'h0000_0087, "R7 reserved write no effect");

    // R9 enable masking
    wr(11'h401, 32'h0000_0004);
    chk({31'b0, irq_o}, 32'h1, "R9 enabled bit2 set");
    wr(11'h400, 32'h0000_0004);
    rd(11'h400, 32'h0000_0083, "R4 clear bit2");
    chk({31'b0, irq_o}, 32'h0, "R9 masked bits no irq");
    wr(11'h401, 32'h0000_0008);
    chk({31'b0, irq_o}, 32'h0, "R9 live enable low");
    set_live(2'b01);
    chk({31'b0, irq_o}, 32'h1, "R9 live enable high");
    set_live(2'b00);

    // R10 unmapped addresses
    rd(11'h403, 32'h0, "R10 unmapped read above");
    rd(11'h000, 32'h0, "R10 unmapped read low");
    wr(11'h3FF, 32'hFFFF_FFFF);
    wr(11'h403, 32'hFFFF_FFFF);
    rd(11'h400, 32'h0000_0083, "R10 status unchanged");
    rd(11'h401, 32'h0000_0008, "R10 enable unchanged");
    rd(11'h402, 32'hA5A5_3C3C, "R10 config unchanged");

    // R2 read data holds
    rd(11'h401, 32'h0000_0008, "R2 read enable");
    repeat (3) @(negedge clk);
    chk(bus_rdata, 32'h0000_0008, "R2 rdata holds");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk(exp_q.size(), 0, "R2 scoreboard drained");
    finished = 1;
    summary();
    $finish;
  end

endmodule